// File: doc/BRIEF.md
# Memory-Mapped Serial Port FIFO Register Front End

This block sits between a processor's 32-bit register bus and the byte-level transmitter and receiver of a serial port. It buffers received characters in a 256-entry receive queue and characters waiting to be sent in a 256-entry transmit queue. Software sees two word registers: a Data word and a Control word. Reading Data pops one received character. The same returned word carries a valid flag and the receive occupancy that remains after the pop. Writing Data appends one character to the transmit queue.

The Control word holds two interrupt enables, one for receive and one for transmit. Reading it shows the pending interrupt flags and the free transmit space. A receive interrupt becomes pending while the receive occupancy is above 31. A transmit interrupt becomes pending while the free transmit space is above 31. A Data read clears the receive flag and a Data write clears the transmit flag.

On the line side, the receiver delivers bytes through a valid strobe with no back-pressure. The transmitter takes bytes through a valid/ready handshake.

Top module: `serial_fifo_regs`

## Requirements
- R1: While reset is asserted and on the cycle after it is released: bus_rdata is 0, irq is 0, tx_out_valid is 0, both queues are empty, and both enables are 0.
- R2: A Data read (bus_rd=1, bus_word=0) of a non-empty receive queue removes the head character. On the next cycle bus_rdata[7:0] is that character, bit 15 is 1, bits 14:8 are 0, and bits 31:16 are the occupancy before the read minus one.
- R3: A Data read of an empty receive queue changes no queue state. On the next cycle bus_rdata is 0 (valid bit 15 = 0, count 0).
- R4: A byte offered on rx_in_valid while the receive queue holds 256 characters is discarded, even when a pop happens in the same cycle.
- R5: A Data write (bus_wr=1, bus_word=0) appends bus_wdata[7:0] to the transmit queue. The queue presents its head in order on tx_out_data, with tx_out_valid high while it is not empty. A byte leaves the queue on a cycle with tx_out_valid and tx_out_ready both high. A Data write while 256 characters are held is discarded.
- R6: A Data write never changes the receive queue or its occupancy.
- R7: A Control read (bus_rd=1, bus_word=1) returns the following on the next cycle: the receive enable in bit 0, the transmit enable in bit 1, the receive pending flag in bit 8, the transmit pending flag in bit 9, and the free transmit space in bits 23:16 (saturated to 255 when the queue is empty). All other bits are 0.
- R8: A Control write (bus_wr=1, bus_word=1) loads the receive enable from bus_wdata[0] and the transmit enable from bus_wdata[1]. All other written bits are ignored.
- R9: The receive pending flag becomes 1 one cycle after a cycle in which the receive enable is 1, no Data read occurs, and the occupancy is above 31. Once set, it holds until a Data read or a cleared enable makes it 0 on the next cycle. The transmit pending flag follows the same rule with free space and Data writes. irq is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | 1 | Register select: 0 Data, 1 Control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| rx_in_valid | input | 1 | Receiver byte strobe |
| rx_in_data | input | 8 | Received byte |
| tx_out_valid | output | 1 | Transmit queue has a byte |
| tx_out_data | output | 8 | Transmit queue head |
| tx_out_ready | input | 1 | Transmitter takes the head byte |
| irq | output | 1 | OR of the pending flags |

## Verification
Read results appear on bus_rdata one edge after the strobe. A written character shows on tx_out_valid one edge after the write. A pending flag rises one edge after the qualifying cycle, which is two edges after the push that lifted the occupancy above 31. The bench drives inputs just after the falling edge and lets its queue-based model advance on the rising edge from the same inputs. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. Directed sequences also sample single results at those points: full-queue drops, the empty read, and the saturated space field.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    // register select values on bus_word
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    // Data read word layout
    localparam int unsigned DATA_VALID_BIT = 15;
    localparam int unsigned DATA_CNT_LSB   = 16;

    // Control word layout
    localparam int unsigned CTRL_RXEN_BIT  = 0;
    localparam int unsigned CTRL_TXEN_BIT  = 1;
    localparam int unsigned CTRL_RXPND_BIT = 8;
    localparam int unsigned CTRL_TXPND_BIT = 9;
    localparam int unsigned CTRL_SPACE_LSB = 16;
    localparam int unsigned CTRL_SPACE_W   = 8;

endpackage

// File: rtl/sfr_fifo.sv
module sfr_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 256,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok, pop_ok;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (pop_ok)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr_ptr] <= push_data;
    end

    assign head  = mem[st_q.rd_ptr];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> ($stable(st_q.cnt) && $stable(st_q.wr_ptr))); // R4

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> ($stable(st_q.rd_ptr) && st_q.cnt == '0)); // R3

    AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R5

endmodule

// File: rtl/sfr_level_flag.sv
module sfr_level_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic cond,
    output logic flag
);
    typedef struct packed {
        logic pend;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en || clr) st_d.pend = 1'b0;
        else if (cond)  st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.pend;

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || clr) |=> !flag); // R9

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && cond) |=> flag); // R9

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && en && !clr) |=> flag); // R9

endmodule

// File: rtl/serial_fifo_regs.sv
module serial_fifo_regs #(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned THRESH = 31,
    parameter int unsigned BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_in_valid,
    input  logic [CHAR_W-1:0] rx_in_data,
    output logic              tx_out_valid,
    output logic [CHAR_W-1:0] tx_out_data,
    input  logic              tx_out_ready,
    output logic              irq
);
    import sfr_pkg::*;

    localparam int unsigned CNT_W     = $clog2(DEPTH + 1);
    localparam int unsigned CNT_FLD_W = BUS_W - DATA_CNT_LSB;
    localparam int unsigned SPACE_MAX = (1 << CTRL_SPACE_W) - 1;

    typedef struct packed {
        logic             rx_en;
        logic             tx_en;
        logic [BUS_W-1:0] rdata;
    } regs_st_t;

    regs_st_t st_d, st_q;

    logic              data_rd, data_wr, ctrl_rd, ctrl_wr;
    logic [CHAR_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt, tx_space;
    logic              rx_full, rx_empty, tx_full, tx_empty;
    logic              rx_pend, tx_pend;
    logic [CTRL_SPACE_W-1:0] space_fld;
    logic              wdata_unused;

    assign data_rd = bus_rd && (bus_word == SEL_DATA);
    assign ctrl_rd = bus_rd && (bus_word == SEL_CTRL);
    assign data_wr = bus_wr && (bus_word == SEL_DATA);
    assign ctrl_wr = bus_wr && (bus_word == SEL_CTRL);
    assign wdata_unused = ^bus_wdata[BUS_W-1:CHAR_W];

    sfr_fifo #(.W(CHAR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_in_valid),
        .push_data (rx_in_data),
        .pop       (data_rd),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    sfr_fifo #(.W(CHAR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (data_wr),
        .push_data (bus_wdata[CHAR_W-1:0]),
        .pop       (tx_out_ready),
        .head      (tx_out_data),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    assign tx_space  = CNT_W'(DEPTH) - tx_cnt;
    assign space_fld = (tx_space > CNT_W'(SPACE_MAX)) ? CTRL_SPACE_W'(SPACE_MAX)
                                                      : CTRL_SPACE_W'(tx_space);

    sfr_level_flag u_rx_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.rx_en),
        .clr   (data_rd),
        .cond  (rx_cnt > CNT_W'(THRESH)),
        .flag  (rx_pend)
    );

    sfr_level_flag u_tx_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.tx_en),
        .clr   (data_wr),
        .cond  (tx_space > CNT_W'(THRESH)),
        .flag  (tx_pend)
    );

    always_comb begin
        st_d = st_q;
        if (data_rd) begin
            st_d.rdata = '0;
            if (!rx_empty) begin
                st_d.rdata[CHAR_W-1:0]     = rx_head;
                st_d.rdata[DATA_VALID_BIT] = 1'b1;
                st_d.rdata[DATA_CNT_LSB +: CNT_FLD_W] = CNT_FLD_W'(rx_cnt - 1'b1);
            end
        end else if (ctrl_rd) begin
            st_d.rdata = '0;
            st_d.rdata[CTRL_RXEN_BIT]  = st_q.rx_en;
            st_d.rdata[CTRL_TXEN_BIT]  = st_q.tx_en;
            st_d.rdata[CTRL_RXPND_BIT] = rx_pend;
            st_d.rdata[CTRL_TXPND_BIT] = tx_pend;
            st_d.rdata[CTRL_SPACE_LSB +: CTRL_SPACE_W] = space_fld;
        end
        if (ctrl_wr) begin
            st_d.rx_en = bus_wdata[CTRL_RXEN_BIT];
            st_d.tx_en = bus_wdata[CTRL_TXEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = st_q.rdata;
    assign tx_out_valid = !tx_empty;
    assign irq          = rx_pend || tx_pend;

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_empty) |=> (bus_rdata[DATA_VALID_BIT] &&
            bus_rdata[DATA_CNT_LSB +: CNT_FLD_W] ==
                CNT_FLD_W'($past(rx_cnt)) - CNT_FLD_W'(1))); // R2

    AST_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_empty && !rx_in_valid) |=> (rx_cnt == $past(rx_cnt) - 1'b1)); // R2

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_empty) |=> (bus_rdata == '0)); // R3

    AST_WRITE_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !data_rd && !rx_in_valid) |=> $stable(rx_cnt)); // R6

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (st_q.rx_en == $past(bus_wdata[CTRL_RXEN_BIT]) &&
                     st_q.tx_en == $past(bus_wdata[CTRL_TXEN_BIT]))); // R8

    AST_TX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !tx_out_ready && !tx_full) |=> tx_out_valid); // R5

endmodule

// File: tb/serial_fifo_regs_tb.sv
module serial_fifo_regs_tb;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        tx_out_valid;
    logic [7:0]  tx_out_data;
    logic        tx_out_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_fifo_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .tx_out_ready(tx_out_ready), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  rxq[$];
    logic [7:0]  txq[$];
    bit          m_re, m_we, m_ri, m_wi;
    logic [31:0] m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_re = 0; m_we = 0; m_ri = 0; m_wi = 0; m_rdata = '0;
        end else begin
            int  rxn, txn, space, sat;
            bit  rd_d, rd_c, wr_d, wr_c, nri, nwi;
            rxn  = rxq.size();
            txn  = txq.size();
            space = DEPTH - txn;
            sat  = (space > 255) ? 255 : space;
            rd_d = bus_rd && !bus_word;
            rd_c = bus_rd && bus_word;
            wr_d = bus_wr && !bus_word;
            wr_c = bus_wr && bus_word;
            if (rd_d) begin
                if (rxn > 0) m_rdata = {16'(rxn - 1), 1'b1, 7'b0, rxq[0]};
                else         m_rdata = '0;
            end else if (rd_c) begin
                m_rdata = {8'b0, 8'(sat), 6'b0, m_wi, m_ri, 6'b0, m_we, m_re};
            end
            nri = !m_re ? 0 : (rd_d ? 0 : (m_ri || rxn > 31));
            nwi = !m_we ? 0 : (wr_d ? 0 : (m_wi || space > 31));
            if (rd_d && rxn > 0) void'(rxq.pop_front());
            if (rx_in_valid && rxn < DEPTH) rxq.push_back(rx_in_data);
            if (tx_out_ready && txn > 0) void'(txq.pop_front());
            if (wr_d && txn < DEPTH) txq.push_back(bus_wdata[7:0]);
            if (wr_c) begin
                m_re = bus_wdata[0];
                m_we = bus_wdata[1];
            end
            m_ri = nri;
            m_wi = nwi;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(bus_rdata == m_rdata, "R2 R3 R7 rdata", bus_rdata, m_rdata);
            check(tx_out_valid == (txq.size() > 0), "R5 tx_out_valid",
                  32'(tx_out_valid), 32'(txq.size() > 0));
            if (txq.size() > 0)
                check(tx_out_data == txq[0], "R5 tx_out_data", 32'(tx_out_data), 32'(txq[0]));
            check(irq == (m_ri || m_wi), "R9 irq", 32'(irq), 32'(m_ri || m_wi));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle_bus();
        bus_rd = 0; bus_wr = 0; bus_word = 0; bus_wdata = '0;
    endtask

    task automatic bus_op(input bit rd, input bit word, input logic [31:0] wd);
        @(negedge clk);
        idle_bus();
        bus_rd = rd; bus_wr = !rd; bus_word = word; bus_wdata = wd;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_in_valid = 1; rx_in_data = b;
        @(negedge clk);
        rx_in_valid = 0;
    endtask

    task automatic finish_sim();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    logic [31:0] lcg = 32'h1234_5678;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(bus_rdata == 0 && irq == 0 && tx_out_valid == 0, "R1 in reset",
              {bus_rdata[29:0], irq, tx_out_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        check(bus_rdata == 0 && irq == 0 && tx_out_valid == 0, "R1 after reset",
              {bus_rdata[29:0], irq, tx_out_valid}, 0);

        // R3: empty read
        bus_op(1, 0, 0);
        check(bus_rdata == 0, "R3 empty read", bus_rdata, 0);

        // R7: control after reset, saturated space
        bus_op(1, 1, 0);
        check(bus_rdata == 32'h00FF_0000, "R7 idle control", bus_rdata, 32'h00FF_0000);

        // R8: enables from low bits, rest ignored
        bus_op(0, 1, 32'hFFFF_FFFD);
        bus_op(1, 1, 0);
        check(bus_rdata[1:0] == 2'b01, "R8 enable load", bus_rdata, 32'h1);

        // R2: a few received characters
        rx_push(8'hA1); rx_push(8'hB2); rx_push(8'hC3);
        bus_op(1, 0, 0);
        check(bus_rdata == 32'h0002_80A1, "R2 first read", bus_rdata, 32'h0002_80A1);

        // R6: data writes leave receive side alone
        bus_op(0, 0, 32'h55); bus_op(0, 0, 32'h66);
        bus_op(1, 0, 0);
        check(bus_rdata == 32'h0001_80B2, "R6 rx after tx writes", bus_rdata, 32'h0001_80B2);
        bus_op(1, 0, 0);
        bus_op(1, 0, 0);
        check(bus_rdata == 0, "R3 drained read", bus_rdata, 0);

        // R5: drain transmit queue
        @(negedge clk); tx_out_ready = 1;
        repeat (3) @(negedge clk);
        tx_out_ready = 0;

        // R4 + R9: overfill receive queue with the receive interrupt enabled
        for (int i = 0; i < DEPTH + 4; i++) begin
            @(negedge clk); rx_in_valid = 1; rx_in_data = 8'(i);
        end
        @(negedge clk); rx_in_valid = 0;
        @(negedge clk);
        check(irq == 1, "R9 rx level irq", 32'(irq), 1);
        bus_op(1, 0, 0);
        check(bus_rdata == 32'h00FF_8000, "R4 full drop count", bus_rdata, 32'h00FF_8000);
        check(irq == 0, "R9 cleared by read", 32'(irq), 0);
        for (int i = 1; i < DEPTH; i++) bus_op(1, 0, 0);
        check(bus_rdata == 32'h0000_80FF, "R4 last kept char", bus_rdata, 32'h0000_80FF);

        // R5: overfill transmit queue
        bus_op(0, 1, 32'h2);
        for (int i = 0; i < DEPTH + 2; i++) bus_op(0, 0, 32'(i + 7));
        bus_op(1, 1, 0);
        check(bus_rdata[23:16] == 0, "R5 full space zero", bus_rdata, 32'h2);
        @(negedge clk); tx_out_ready = 1;
        repeat (DEPTH + 2) @(negedge clk);
        tx_out_ready = 0;

        // mixed random traffic
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            idle_bus();
            lcg = nxt(lcg);
            rx_in_valid  = lcg[20];
            rx_in_data   = lcg[31:24];
            tx_out_ready = lcg[21] & lcg[22];
            case (lcg[18:16])
                3'd0, 3'd1: begin bus_rd = 1; bus_word = 0; end
                3'd2, 3'd3: begin bus_wr = 1; bus_word = 0; bus_wdata = {24'h0, lcg[15:8]}; end
                3'd4:       begin bus_rd = 1; bus_word = 1; end
                3'd5:       if (lcg[7:4] == 0) begin
                                bus_wr = 1; bus_word = 1; bus_wdata = {30'h0, lcg[1:0]};
                            end
                default: ;
            endcase
        end
        @(negedge clk);
        idle_bus(); rx_in_valid = 0; tx_out_ready = 0;
        repeat (4) @(negedge clk);
        finish_sim();
    end

endmodule